// File: doc/BRIEF.md
# Tagged Fully Associative Page Translation Cache

This block turns a 24-bit virtual address into a 32-bit physical address within the same cycle. It compares the page-number bits of the address against every stored mapping in parallel. A stored mapping holds a page number, a frame number, an owner process id, and status flags: valid, writable, referenced and dirty. The block only matches mappings whose owner id equals the current-process register.

When no mapping matches, the block raises a miss fault and does nothing else. The trap handler reads the page table, picks a victim slot and loads the mapping through the fill port. It then retries the access. A write to a mapping that is not writable raises a protection fault instead. The block keeps referenced and dirty flags per mapping and reports them on every hit. A flush input drops every mapping at once when the operating system switches context without relying on the id tags.

Top module: `xlat_cache`

## Requirements
- R1: On a hit, paddr_o[31:13] is the stored frame number of the selected mapping and paddr_o[12:0] equals vaddr_i[12:0]. The page number used for matching is vaddr_i[23:13].
- R2: A lookup hits only if a mapping meets all three conditions: it is valid, its page number equals vaddr_i[23:13], and its owner id equals the current-process register. That register loads pid_i on a clock edge where pid_set_i is high and takes effect from the next cycle.
- R3: A lookup with no matching mapping raises miss_fault_o for that cycle, with hit_o and prot_fault_o low and paddr_o zero. It changes no stored state.
- R4: A write lookup (is_write_i=1) that matches a mapping whose writable flag is clear raises prot_fault_o, keeps hit_o and miss_fault_o low and drives paddr_o to zero. It leaves that mapping's referenced and dirty flags unchanged.
- R5: A hit sets the selected mapping's referenced flag, and a write hit also sets its dirty flag. hit_ref_o and hit_dirty_o report the flags as stored before the current lookup.
- R6: When several valid mappings match, the one with the lowest slot index is selected, and hit_idx_o gives that index.
- R7: With flush_i high on a clock edge, every mapping becomes invalid. A fill and a flag update in that same cycle are discarded.
- R8: A fill writes slot fill_idx_i with the given page, frame, owner id and writable flag, marks it valid and clears its referenced and dirty flags. A fill takes precedence over a flag update of the same slot in the same cycle.
- R9: After reset, every mapping is invalid and the current-process register is 0.
- R10: While lookup_valid_i is low, hit_o, miss_fault_o, prot_fault_o, paddr_o, hit_idx_o, hit_ref_o and hit_dirty_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pid_set_i | input | 1 | Load the current-process register |
| pid_i | input | 8 | New current-process id |
| flush_i | input | 1 | Invalidate all mappings |
| fill_en_i | input | 1 | Write a mapping |
| fill_idx_i | input | 6 | Slot to write |
| fill_page_i | input | 11 | Page number of the new mapping |
| fill_frame_i | input | 19 | Frame number of the new mapping |
| fill_pid_i | input | 8 | Owner process id of the new mapping |
| fill_writable_i | input | 1 | Writable flag of the new mapping |
| lookup_valid_i | input | 1 | A translation is requested this cycle |
| vaddr_i | input | 24 | Virtual address |
| is_write_i | input | 1 | Access is a write |
| hit_o | output | 1 | Translation succeeded |
| paddr_o | output | 32 | Physical address |
| miss_fault_o | output | 1 | No mapping found |
| prot_fault_o | output | 1 | Write to a non-writable mapping |
| hit_idx_o | output | 6 | Slot that produced the hit |
| hit_ref_o | output | 1 | Referenced flag of the hit slot before this lookup |
| hit_dirty_o | output | 1 | Dirty flag of the hit slot before this lookup |

## Verification
The hardest situation to reach is several live mappings for the same page and owner sitting in different slots, since software would normally avoid loading one twice. To create it, the random fills draw pages from a pool of eight and owner ids from a pool of three, and scatter them over all slots. Duplicates then arise constantly, and the lowest-index choice is exercised along with its flag updates. Directed steps add the other cases. A fill is given in the same cycle as a flush. Read-only slots are written to. The current id is switched away from an owner that still has live mappings.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  localparam int unsigned XLAT_ENTRIES = 64;
  localparam int unsigned XLAT_VA_W    = 24;
  localparam int unsigned XLAT_PA_W    = 32;
  localparam int unsigned XLAT_OFF_W   = 13;
  localparam int unsigned XLAT_PID_W   = 8;

  typedef enum logic [1:0] {
    XO_NONE,
    XO_HIT,
    XO_MISS,
    XO_PROT
  } xlat_res_e;
endpackage

// File: rtl/xlat_entry_array.sv
`timescale 1ns/1ps
module xlat_entry_array #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned VPN_W   = 11,
  parameter int unsigned PFN_W   = 19,
  parameter int unsigned PID_W   = 8,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            flush_i,
  input  logic                            fill_en_i,
  input  logic [IDX_W-1:0]                fill_idx_i,
  input  logic [VPN_W-1:0]                fill_page_i,
  input  logic [PFN_W-1:0]                fill_frame_i,
  input  logic [PID_W-1:0]                fill_pid_i,
  input  logic                            fill_writable_i,
  input  logic                            upd_en_i,
  input  logic [IDX_W-1:0]                upd_idx_i,
  input  logic                            upd_dirty_i,
  output logic [ENTRIES-1:0]              valid_o,
  output logic [ENTRIES-1:0]              writable_o,
  output logic [ENTRIES-1:0]              ref_o,
  output logic [ENTRIES-1:0]              dirty_o,
  output logic [ENTRIES-1:0][VPN_W-1:0]   page_o,
  output logic [ENTRIES-1:0][PFN_W-1:0]   frame_o,
  output logic [ENTRIES-1:0][PID_W-1:0]   pid_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             val_q, wr_q, ref_q, dty_q;
    logic [VPN_W-1:0] pg_q;
    logic [PFN_W-1:0] fr_q;
    logic [PID_W-1:0] pid_q;
    logic             fill_hit, upd_hit;

    assign fill_hit = fill_en_i && (fill_idx_i == IDX_W'(g));
    assign upd_hit  = upd_en_i  && (upd_idx_i  == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= 1'b0;
        wr_q  <= 1'b0;
        ref_q <= 1'b0;
        dty_q <= 1'b0;
        pg_q  <= '0;
        fr_q  <= '0;
        pid_q <= '0;
      end else if (flush_i) begin
        val_q <= 1'b0;
      end else if (fill_hit) begin
        val_q <= 1'b1;
        wr_q  <= fill_writable_i;
        ref_q <= 1'b0;
        dty_q <= 1'b0;
        pg_q  <= fill_page_i;
        fr_q  <= fill_frame_i;
        pid_q <= fill_pid_i;
      end else if (upd_hit) begin
        ref_q <= 1'b1;
        if (upd_dirty_i) dty_q <= 1'b1;
      end
    end

    assign valid_o[g]    = val_q;
    assign writable_o[g] = wr_q;
    assign ref_o[g]      = ref_q;
    assign dirty_o[g]    = dty_q;
    assign page_o[g]     = pg_q;
    assign frame_o[g]    = fr_q;
    assign pid_o[g]      = pid_q;
  end
endmodule

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
module xlat_match #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned VPN_W   = 11,
  parameter int unsigned PID_W   = 8
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0] page_i,
  input  logic [ENTRIES-1:0][PID_W-1:0] pid_i,
  input  logic [VPN_W-1:0]              look_page_i,
  input  logic [PID_W-1:0]              cur_pid_i,
  output logic [ENTRIES-1:0]            match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (page_i[g] == look_page_i) && (pid_i[g] == cur_pid_i);
  end
endmodule

// File: rtl/xlat_pick_lowest.sv
`timescale 1ns/1ps
module xlat_pick_lowest #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] req_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign found_o = |req_i;
endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = XLAT_ENTRIES,
  parameter int unsigned VA_W    = XLAT_VA_W,
  parameter int unsigned PA_W    = XLAT_PA_W,
  parameter int unsigned OFF_W   = XLAT_OFF_W,
  parameter int unsigned PID_W   = XLAT_PID_W,
  localparam int unsigned VPN_W  = VA_W - OFF_W,
  localparam int unsigned PFN_W  = PA_W - OFF_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pid_set_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic             flush_i,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [VPN_W-1:0] fill_page_i,
  input  logic [PFN_W-1:0] fill_frame_i,
  input  logic [PID_W-1:0] fill_pid_i,
  input  logic             fill_writable_i,
  input  logic             lookup_valid_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic             is_write_i,
  output logic             hit_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             miss_fault_o,
  output logic             prot_fault_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output logic             hit_ref_o,
  output logic             hit_dirty_o
);
  logic [PID_W-1:0]              cur_pid_q;
  logic [ENTRIES-1:0]            ent_valid, ent_wr, ent_ref, ent_dirty, ent_match;
  logic [ENTRIES-1:0][VPN_W-1:0] ent_page;
  logic [ENTRIES-1:0][PFN_W-1:0] ent_frame;
  logic [ENTRIES-1:0][PID_W-1:0] ent_pid;
  logic                          found;
  logic [IDX_W-1:0]              sel_idx;
  xlat_res_e                     res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cur_pid_q <= '0;
    else if (pid_set_i) cur_pid_q <= pid_i;
  end

  xlat_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W)
  ) i_array (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .flush_i        (flush_i),
    .fill_en_i      (fill_en_i),
    .fill_idx_i     (fill_idx_i),
    .fill_page_i    (fill_page_i),
    .fill_frame_i   (fill_frame_i),
    .fill_pid_i     (fill_pid_i),
    .fill_writable_i(fill_writable_i),
    .upd_en_i       (hit_o),
    .upd_idx_i      (sel_idx),
    .upd_dirty_i    (is_write_i),
    .valid_o        (ent_valid),
    .writable_o     (ent_wr),
    .ref_o          (ent_ref),
    .dirty_o        (ent_dirty),
    .page_o         (ent_page),
    .frame_o        (ent_frame),
    .pid_o          (ent_pid)
  );

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) i_match (
    .valid_i    (ent_valid),
    .page_i     (ent_page),
    .pid_i      (ent_pid),
    .look_page_i(vaddr_i[VA_W-1:OFF_W]),
    .cur_pid_i  (cur_pid_q),
    .match_o    (ent_match)
  );

  xlat_pick_lowest #(.ENTRIES(ENTRIES)) i_pick (
    .req_i  (ent_match),
    .found_o(found),
    .idx_o  (sel_idx)
  );

  always_comb begin
    if (!lookup_valid_i)                  res = XO_NONE;
    else if (!found)                      res = XO_MISS;
    else if (is_write_i && !ent_wr[sel_idx]) res = XO_PROT;
    else                                  res = XO_HIT;
  end

  assign hit_o        = (res == XO_HIT);
  assign miss_fault_o = (res == XO_MISS);
  assign prot_fault_o = (res == XO_PROT);
  assign paddr_o      = hit_o ? {ent_frame[sel_idx], vaddr_i[OFF_W-1:0]} : '0;
  assign hit_idx_o    = hit_o ? sel_idx : '0;
  assign hit_ref_o    = hit_o && ent_ref[sel_idx];
  assign hit_dirty_o  = hit_o && ent_dirty[sel_idx];
endmodule

// File: rtl/xlat_cache_chk.sv
`timescale 1ns/1ps
module xlat_cache_chk #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned VA_W    = 24,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned OFF_W   = 13,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               flush_i,
  input logic               fill_en_i,
  input logic [IDX_W-1:0]   fill_idx_i,
  input logic               lookup_valid_i,
  input logic [VA_W-1:0]    vaddr_i,
  input logic               is_write_i,
  input logic               hit_o,
  input logic [PA_W-1:0]    paddr_o,
  input logic               miss_fault_o,
  input logic               prot_fault_o,
  input logic [IDX_W-1:0]   hit_idx_o,
  input logic [ENTRIES-1:0] ent_ref,
  input logic [ENTRIES-1:0] ent_dirty
);
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |-> $countones({hit_o, miss_fault_o, prot_fault_o}) == 1); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |-> !hit_o && !miss_fault_o && !prot_fault_o && paddr_o == '0); // R10

  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> paddr_o[OFF_W-1:0] == vaddr_i[OFF_W-1:0]); // R1

  AST_FAULT_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_fault_o || prot_fault_o) |-> paddr_o == '0); // R4

  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (lookup_valid_i -> miss_fault_o)); // R7

  AST_REF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !flush_i && !(fill_en_i && fill_idx_i == hit_idx_o)) |=> ent_ref[$past(hit_idx_o)]); // R5

  AST_DIRTY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && is_write_i && !flush_i && !(fill_en_i && fill_idx_i == hit_idx_o))
      |=> ent_dirty[$past(hit_idx_o)]); // R5
endmodule

bind xlat_cache xlat_cache_chk #(
  .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)
) i_xlat_cache_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .fill_en_i     (fill_en_i),
  .fill_idx_i    (fill_idx_i),
  .lookup_valid_i(lookup_valid_i),
  .vaddr_i       (vaddr_i),
  .is_write_i    (is_write_i),
  .hit_o         (hit_o),
  .paddr_o       (paddr_o),
  .miss_fault_o  (miss_fault_o),
  .prot_fault_o  (prot_fault_o),
  .hit_idx_o     (hit_idx_o),
  .ent_ref       (ent_ref),
  .ent_dirty     (ent_dirty)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;
  localparam int N = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pid_set_i = 0;
  logic [7:0]  pid_i = 0;
  logic        flush_i = 0;
  logic        fill_en_i = 0;
  logic [5:0]  fill_idx_i = 0;
  logic [10:0] fill_page_i = 0;
  logic [18:0] fill_frame_i = 0;
  logic [7:0]  fill_pid_i = 0;
  logic        fill_writable_i = 0;
  logic        lookup_valid_i = 0;
  logic [23:0] vaddr_i = 0;
  logic        is_write_i = 0;
  logic        hit_o, miss_fault_o, prot_fault_o, hit_ref_o, hit_dirty_o;
  logic [31:0] paddr_o;
  logic [5:0]  hit_idx_o;

  int errs = 0, checks = 0;
  bit done = 0;

  bit        m_val[N], m_wr[N], m_ref[N], m_dty[N];
  bit [10:0] m_pg[N];
  bit [18:0] m_fr[N];
  bit [7:0]  m_pid[N];
  bit [7:0]  m_cur;

  always #10 clk_i = ~clk_i;

  xlat_cache i_xlat_cache (.*);

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", rq, what, act, exp, $time);
    end
  endtask

  function automatic int find_lowest(bit [10:0] pg, bit [7:0] pid);
    for (int i = 0; i < N; i++)
      if (m_val[i] && m_pg[i] == pg && m_pid[i] == pid) return i;
    return -1;
  endfunction

  // one clock: drive after negedge, sample mid-low phase, update model after posedge
  task automatic step(bit lk, bit [23:0] va, bit wr, bit fl, bit fe, int fidx,
                      bit [10:0] fpg, bit [18:0] ffr, bit [7:0] fpid, bit fw,
                      bit ps, bit [7:0] pv);
    int  e;
    bit  exp_hit, exp_prot;
    @(negedge clk_i);
    lookup_valid_i = lk; vaddr_i = va; is_write_i = wr; flush_i = fl;
    fill_en_i = fe; fill_idx_i = 6'(fidx); fill_page_i = fpg; fill_frame_i = ffr;
    fill_pid_i = fpid; fill_writable_i = fw; pid_set_i = ps; pid_i = pv;
    #5;
    e = find_lowest(va[23:13], m_cur);
    exp_hit = 0; exp_prot = 0;
    if (!lk) begin
      chk(!hit_o && !miss_fault_o && !prot_fault_o && paddr_o == 0 && hit_idx_o == 0
          && !hit_ref_o && !hit_dirty_o, "R10", "idle outputs", {hit_o, miss_fault_o, prot_fault_o}, 0);
    end else if (e < 0) begin
      chk(miss_fault_o && !hit_o && !prot_fault_o && paddr_o == 0, "R3", "miss",
          {hit_o, miss_fault_o, prot_fault_o}, 3'b010);
    end else if (wr && !m_wr[e]) begin
      exp_prot = 1;
      chk(prot_fault_o && !hit_o && !miss_fault_o && paddr_o == 0, "R4", "prot fault",
          {hit_o, miss_fault_o, prot_fault_o}, 3'b001);
    end else begin
      exp_hit = 1;
      chk(hit_o && !miss_fault_o && !prot_fault_o, "R2", "hit",
          {hit_o, miss_fault_o, prot_fault_o}, 3'b100);
      chk(paddr_o == {m_fr[e], va[12:0]}, "R1", "paddr", paddr_o, {m_fr[e], va[12:0]});
      chk(hit_idx_o == 6'(e), "R6", "lowest index", hit_idx_o, e);
      chk(hit_ref_o == m_ref[e] && hit_dirty_o == m_dty[e], "R5", "ref/dirty",
          {hit_ref_o, hit_dirty_o}, {m_ref[e], m_dty[e]});
    end
    @(posedge clk_i);
    #1;
    if (fl) begin
      for (int i = 0; i < N; i++) m_val[i] = 0;
    end else begin
      if (exp_hit) begin
        m_ref[e] = 1;
        if (wr) m_dty[e] = 1;
      end
      if (fe) begin
        m_val[fidx] = 1; m_wr[fidx] = fw; m_ref[fidx] = 0; m_dty[fidx] = 0;
        m_pg[fidx] = fpg; m_fr[fidx] = ffr; m_pid[fidx] = fpid;
      end
    end
    if (ps) m_cur = pv;
  endtask

  task automatic look(bit [10:0] pg, bit [12:0] off, bit wr);
    step(1, {pg, off}, wr, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(int idx, bit [10:0] pg, bit [18:0] fr, bit [7:0] pid, bit w);
    step(0, 0, 0, 0, 1, idx, pg, fr, pid, w, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog all requirements act=timeout exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin
      m_val[i] = 0; m_wr[i] = 0; m_ref[i] = 0; m_dty[i] = 0;
      m_pg[i] = 0; m_fr[i] = 0; m_pid[i] = 0;
    end
    m_cur = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R9: empty after reset, pid 0
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    look(11'd3, 13'h0aa, 0);
    look(11'd0, 13'h000, 1);

    // basic mapping, ref then dirty progression (R1 R2 R5)
    fill(5, 11'd3, 19'h12345, 8'd0, 1);
    look(11'd3, 13'h1abc, 0);
    look(11'd3, 13'h0001, 1);
    look(11'd3, 13'h1fff, 0);

    // duplicates: lower slot wins (R6)
    fill(2, 11'd3, 19'h00777, 8'd0, 1);
    fill(40, 11'd3, 19'h7ffff, 8'd0, 1);
    look(11'd3, 13'h0123, 0);

    // owner tag mismatch and register timing (R2)
    step(1, {11'd3, 13'h5}, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'd1);
    look(11'd3, 13'h5, 0);
    fill(9, 11'd3, 19'h0abcd, 8'd1, 1);
    look(11'd3, 13'h6, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'd0);

    // read-only: write faults and leaves flags (R4)
    fill(7, 11'd9, 19'h22222, 8'd0, 0);
    look(11'd9, 13'h10, 1);
    look(11'd9, 13'h10, 0);
    look(11'd9, 13'h10, 0);

    // fill beats flag update on same slot (R8)
    step(1, {11'd3, 13'h44}, 1, 0, 1, 2, 11'd3, 19'h33333, 8'd0, 1, 0, 0);
    look(11'd3, 13'h44, 0);

    // flush discards fill in same cycle (R7)
    step(0, 0, 0, 1, 1, 10, 11'd20, 19'h01010, 8'd0, 1, 0, 0);
    look(11'd20, 13'h0, 0);
    look(11'd3, 13'h0, 0);
    look(11'd9, 13'h0, 1);

    // refill clears stale flags (R8)
    fill(5, 11'd3, 19'h00042, 8'd0, 1);
    look(11'd3, 13'h8, 1);
    look(11'd3, 13'h8, 0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit lk, fl, fe, ps;
      lk = ($urandom % 4) != 0;
      fl = ($urandom % 80) == 0;
      fe = ($urandom % 3) == 0;
      ps = ($urandom % 40) == 0;
      step(lk, {11'($urandom % 8), 13'($urandom)}, 1'($urandom), fl, fe,
           int'($urandom % N), 11'($urandom % 8), 19'($urandom), 8'($urandom % 3),
           1'(($urandom % 4) != 0), ps, 8'($urandom % 3));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule